// File: doc/BRIEF.md
# Dual Synthesizer Divider and Phase Detector Core

This block is the digital heart of a two-loop frequency synthesizer. One programmable reference divider turns crystal ticks into a comparison pulse train. That train is shared by a transmit loop and a receive loop. Each loop divides its own oscillator ticks with a programmable feedback divider and compares the two pulse trains in a three-state phase detector. The detector drives pump-up and pump-down enables and reports a lock flag. Each loop also has a power-down input and a registered two-level pump current select. The analog pumps, the oscillators and the loop filters sit outside.

All logic runs on one sampling clock. The crystal and the oscillator edges arrive as single-cycle tick strobes that have already been synchronised. The locked oscillator rate is N times the comparison rate, and the comparison rate is the crystal rate divided by R. For example, a 10.240 MHz crystal with R = 2048 gives 5 kHz, and N = 7183 then gives 35.915 MHz. Divide values are loaded only at a terminal count, so a value written in the middle of a period never cuts that period short.

Top module: `dual_synth_core`

## Requirements
- R1: `ref_pulse_o` is high for exactly one clock, in the cycle after the reference tick that completes a period. Successive pulses are R reference ticks apart, so with a tick on every clock they are R clocks apart.
- R2: A reference or feedback divide value below 5 behaves exactly as 5.
- R3: After reset every divider runs its first period with a value of 5. A new divide value written part-way through a period takes effect only after that period ends.
- R4: A divider advances only in clock cycles in which its tick input is high.
- R5: When a reference pulse comes first, up is high for exactly the number of clocks until the matching feedback pulse. When the feedback pulse comes first, down is high in the same way. When the two pulses coincide, neither output goes high. Up and down are never high together.
- R6: The lock flag rises in the clock after the 8th consecutive comparison whose error pulse is shorter than 4 clocks. It stays low until then. Any error pulse of 4 clocks or longer clears the flag and restarts the count.
- R7: A reference running faster than the feedback produces only up pulses, and the loop never locks. A faster feedback produces only down pulses.
- R8: From the clock after a loop's power-down input is high, that loop's up, down, lock and current-select outputs are low and its feedback divider is held. The other loop is unaffected.
- R9: While a loop is enabled, its current-select output follows its current-select input, one clock later. A value of 1 selects the double current and 0 selects the low current.
- R10: The largest reference value, 4095, gives a period of 4095 ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref_tick_i | input | 1 | One-cycle strobe per crystal edge |
| ref_div_i | input | 12 | Reference divide value R |
| tx_vco_tick_i | input | 1 | One-cycle strobe per transmit oscillator edge |
| tx_div_i | input | 14 | Transmit feedback divide value N |
| tx_pd_i | input | 1 | Transmit loop power-down |
| tx_cp_hi_i | input | 1 | Transmit pump double-current request |
| rx_vco_tick_i | input | 1 | One-cycle strobe per receive oscillator edge |
| rx_div_i | input | 14 | Receive feedback divide value N |
| rx_pd_i | input | 1 | Receive loop power-down |
| rx_cp_hi_i | input | 1 | Receive pump double-current request |
| ref_pulse_o | output | 1 | Comparison-rate pulse from the reference divider |
| tx_up_o | output | 1 | Transmit pump-up enable |
| tx_dn_o | output | 1 | Transmit pump-down enable |
| tx_cp_hi_o | output | 1 | Transmit pump current select |
| tx_lock_o | output | 1 | Transmit loop lock flag |
| rx_up_o | output | 1 | Receive pump-up enable |
| rx_dn_o | output | 1 | Receive pump-down enable |
| rx_cp_hi_o | output | 1 | Receive pump current select |
| rx_lock_o | output | 1 | Receive loop lock flag |

## Verification
The bench fixes the phase offset between the reference and feedback trains by delaying one tick stream. This puts the error pulse at 3 clocks, just under the lock threshold, and at 4 clocks, just at it. A detector that counted widths one off would lock at 4 clocks or refuse to lock at 3. A divide value is changed one cycle after a terminal count: a divider that loaded at once would give a short 6-cycle period where 20 is expected. A design that skipped the clamp would see its 3-versus-5 and 0-versus-2 loops drift apart and never lock. The bench also powers one loop down while the other stays locked, which catches a shared enable or a missing gate on the current select.

// File: rtl/ds_pkg.sv
package ds_pkg;
  localparam int REF_W_DEF    = 12;
  localparam int FB_W_DEF     = 14;
  localparam int DIV_MIN_DEF  = 5;
  localparam int LOCK_TH_DEF  = 4;
  localparam int LOCK_CNT_DEF = 8;
  localparam int NUM_LOOPS    = 2;
  localparam int LOOP_TX      = 0;
  localparam int LOOP_RX      = 1;

  typedef struct packed {
    logic up;
    logic dn;
    logic cp_hi;
    logic lock;
  } loop_out_t;
endpackage

// File: rtl/ds_divider.sv
module ds_divider #(
  parameter int W   = 12,
  parameter int MIN = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         tick_i,
  input  logic [W-1:0] div_i,
  output logic         tc_o
);
  localparam logic [W-1:0] MinVal = W'(MIN);

  logic [W-1:0] cnt_q, div_q, div_eff;
  logic         tc_q;

  assign div_eff = (div_i < MinVal) ? MinVal : div_i;

  // active value reloads only at terminal count: no runt periods
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      div_q <= MinVal;
      tc_q  <= 1'b0;
    end else if (!en_i) begin
      cnt_q <= '0;
      div_q <= div_eff;
      tc_q  <= 1'b0;
    end else begin
      tc_q <= 1'b0;
      if (tick_i) begin
        if (cnt_q == div_q - W'(1)) begin
          cnt_q <= '0;
          div_q <= div_eff;
          tc_q  <= 1'b1;
        end else begin
          cnt_q <= cnt_q + W'(1);
        end
      end
    end
  end

  assign tc_o = tc_q;
endmodule

// File: rtl/ds_pfd.sv
module ds_pfd #(
  parameter int LOCK_TH  = 4,
  parameter int LOCK_CNT = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic ref_i,
  input  logic fb_i,
  output logic up_o,
  output logic dn_o,
  output logic lock_o
);
  localparam int WC_W = $clog2(LOCK_TH + 1);
  localparam int GC_W = $clog2(LOCK_CNT + 1);
  localparam logic [WC_W:0]   ThExt  = (WC_W+1)'(LOCK_TH);
  localparam logic [WC_W-1:0] ThSat  = WC_W'(LOCK_TH);
  localparam logic [GC_W-1:0] CntTop = GC_W'(LOCK_CNT - 1);

  logic            up_q, dn_q, lock_q;
  logic            up_n, dn_n, clr, act, good, bad;
  logic [WC_W-1:0] wcnt_q;
  logic [WC_W:0]   width_now;
  logic [GC_W-1:0] gcnt_q;

  assign up_n      = up_q | ref_i;
  assign dn_n      = dn_q | fb_i;
  assign clr       = up_n & dn_n;
  assign act       = up_q | dn_q;
  assign width_now = {1'b0, wcnt_q} + {{WC_W{1'b0}}, act};
  assign good      = clr && (width_now < ThExt);
  // long or never-ending error pulses count against lock
  assign bad       = act && (width_now >= ThExt);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      up_q   <= 1'b0;
      dn_q   <= 1'b0;
      wcnt_q <= '0;
      gcnt_q <= '0;
      lock_q <= 1'b0;
    end else if (!en_i) begin
      up_q   <= 1'b0;
      dn_q   <= 1'b0;
      wcnt_q <= '0;
      gcnt_q <= '0;
      lock_q <= 1'b0;
    end else begin
      up_q <= up_n & ~clr;
      dn_q <= dn_n & ~clr;
      if (clr || !act)        wcnt_q <= '0;
      else if (wcnt_q != ThSat) wcnt_q <= wcnt_q + WC_W'(1);
      if (bad) begin
        gcnt_q <= '0;
        lock_q <= 1'b0;
      end else if (good) begin
        if (gcnt_q == CntTop) lock_q <= 1'b1;
        if (gcnt_q != CntTop + GC_W'(1)) gcnt_q <= gcnt_q + GC_W'(1);
      end
    end
  end

  assign up_o   = up_q;
  assign dn_o   = dn_q;
  assign lock_o = lock_q;
endmodule

// File: rtl/dual_synth_core.sv
module dual_synth_core import ds_pkg::*; #(
  parameter int REF_W    = REF_W_DEF,
  parameter int FB_W     = FB_W_DEF,
  parameter int DIV_MIN  = DIV_MIN_DEF,
  parameter int LOCK_TH  = LOCK_TH_DEF,
  parameter int LOCK_CNT = LOCK_CNT_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ref_tick_i,
  input  logic [REF_W-1:0] ref_div_i,
  input  logic             tx_vco_tick_i,
  input  logic [FB_W-1:0]  tx_div_i,
  input  logic             tx_pd_i,
  input  logic             tx_cp_hi_i,
  input  logic             rx_vco_tick_i,
  input  logic [FB_W-1:0]  rx_div_i,
  input  logic             rx_pd_i,
  input  logic             rx_cp_hi_i,
  output logic             ref_pulse_o,
  output logic             tx_up_o,
  output logic             tx_dn_o,
  output logic             tx_cp_hi_o,
  output logic             tx_lock_o,
  output logic             rx_up_o,
  output logic             rx_dn_o,
  output logic             rx_cp_hi_o,
  output logic             rx_lock_o
);
  logic                 ref_tc;
  logic [NUM_LOOPS-1:0] vco_tick, pd, cp_req;
  logic [FB_W-1:0]      fb_div [NUM_LOOPS];
  loop_out_t            lo     [NUM_LOOPS];

  assign vco_tick[LOOP_TX] = tx_vco_tick_i;
  assign vco_tick[LOOP_RX] = rx_vco_tick_i;
  assign pd[LOOP_TX]       = tx_pd_i;
  assign pd[LOOP_RX]       = rx_pd_i;
  assign cp_req[LOOP_TX]   = tx_cp_hi_i;
  assign cp_req[LOOP_RX]   = rx_cp_hi_i;
  assign fb_div[LOOP_TX]   = tx_div_i;
  assign fb_div[LOOP_RX]   = rx_div_i;

  // shared comparison-rate divider, always running
  ds_divider #(.W(REF_W), .MIN(DIV_MIN)) u_ref_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (1'b1),
    .tick_i (ref_tick_i),
    .div_i  (ref_div_i),
    .tc_o   (ref_tc)
  );

  for (genvar g = 0; g < NUM_LOOPS; g++) begin : g_loop
    logic fb_tc, cp_q;

    ds_divider #(.W(FB_W), .MIN(DIV_MIN)) u_fb_div (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (~pd[g]),
      .tick_i (vco_tick[g]),
      .div_i  (fb_div[g]),
      .tc_o   (fb_tc)
    );

    ds_pfd #(.LOCK_TH(LOCK_TH), .LOCK_CNT(LOCK_CNT)) u_pfd (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (~pd[g]),
      .ref_i  (ref_tc),
      .fb_i   (fb_tc),
      .up_o   (lo[g].up),
      .dn_o   (lo[g].dn),
      .lock_o (lo[g].lock)
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) cp_q <= 1'b0;
      else         cp_q <= cp_req[g] & ~pd[g];
    end
    assign lo[g].cp_hi = cp_q;
  end

  assign ref_pulse_o = ref_tc;
  assign tx_up_o     = lo[LOOP_TX].up;
  assign tx_dn_o     = lo[LOOP_TX].dn;
  assign tx_cp_hi_o  = lo[LOOP_TX].cp_hi;
  assign tx_lock_o   = lo[LOOP_TX].lock;
  assign rx_up_o     = lo[LOOP_RX].up;
  assign rx_dn_o     = lo[LOOP_RX].dn;
  assign rx_cp_hi_o  = lo[LOOP_RX].cp_hi;
  assign rx_lock_o   = lo[LOOP_RX].lock;
endmodule

// File: rtl/ds_checker.sv
module ds_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic ref_pulse_i,
  input logic tx_pd_i,
  input logic tx_up_i,
  input logic tx_dn_i,
  input logic tx_cp_i,
  input logic tx_lock_i,
  input logic rx_pd_i,
  input logic rx_up_i,
  input logic rx_dn_i,
  input logic rx_cp_i,
  input logic rx_lock_i
);
  a_r1_ref_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_pulse_i |=> !ref_pulse_i);

  a_r5_tx_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(tx_up_i && tx_dn_i));
  a_r5_rx_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rx_up_i && rx_dn_i));

  a_r6_tx_lock_clean: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_lock_i) |-> (!tx_up_i && !tx_dn_i));
  a_r6_rx_lock_clean: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rx_lock_i) |-> (!rx_up_i && !rx_dn_i));

  a_r8_tx_pd_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_pd_i |=> (!tx_up_i && !tx_dn_i && !tx_lock_i && !tx_cp_i));
  a_r8_rx_pd_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_pd_i |=> (!rx_up_i && !rx_dn_i && !rx_lock_i && !rx_cp_i));
endmodule

bind dual_synth_core ds_checker u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ref_pulse_i (ref_pulse_o),
  .tx_pd_i     (tx_pd_i),
  .tx_up_i     (tx_up_o),
  .tx_dn_i     (tx_dn_o),
  .tx_cp_i     (tx_cp_hi_o),
  .tx_lock_i   (tx_lock_o),
  .rx_pd_i     (rx_pd_i),
  .rx_up_i     (rx_up_o),
  .rx_dn_i     (rx_dn_o),
  .rx_cp_i     (rx_cp_hi_o),
  .rx_lock_i   (rx_lock_o)
);

// File: tb/sim_dual_synth_core.sv
module sim_dual_synth_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ref_tick = 1'b0, tx_tick = 1'b0, rx_tick = 1'b0;
  logic [11:0] ref_div = 12'd8;
  logic [13:0] tx_div = 14'd8, rx_div = 14'd8;
  logic        tx_pd = 1'b0, rx_pd = 1'b0, tx_cp = 1'b0, rx_cp = 1'b0;
  logic        ref_pulse, tx_up, tx_dn, tx_cph, tx_lock, rx_up, rx_dn, rx_cph, rx_lock;

  always #10 clk = ~clk;

  dual_synth_core u0 (
    .clk_i(clk), .rst_ni(rst_n), .ref_tick_i(ref_tick), .ref_div_i(ref_div),
    .tx_vco_tick_i(tx_tick), .tx_div_i(tx_div), .tx_pd_i(tx_pd), .tx_cp_hi_i(tx_cp),
    .rx_vco_tick_i(rx_tick), .rx_div_i(rx_div), .rx_pd_i(rx_pd), .rx_cp_hi_i(rx_cp),
    .ref_pulse_o(ref_pulse), .tx_up_o(tx_up), .tx_dn_o(tx_dn), .tx_cp_hi_o(tx_cph),
    .tx_lock_o(tx_lock), .rx_up_o(rx_up), .rx_dn_o(rx_dn), .rx_cp_hi_o(rx_cph),
    .rx_lock_o(rx_lock)
  );

  int n_chk = 0, n_err = 0;
  int cyc = 0, ref_n = 0, ref_iv = 0, last_ref = 0;
  int up_run = 0, dn_run = 0, max_up = 0, max_dn = 0;
  bit ref_prev = 1'b0, ref_wide = 1'b0;

  // R, N, ref delay, vco delay, lock, max up width, max down width, kind
  localparam int VEC [9][8] = '{
    '{8, 8, 0, 0, 1, 0, 0, 0},
    '{8, 8, 0, 3, 1, 3, 0, 0},
    '{8, 8, 0, 4, 0, 4, 0, 0},
    '{8, 8, 2, 0, 1, 0, 2, 0},
    '{8, 8, 5, 0, 0, 0, 5, 0},
    '{8, 9, 0, 0, 0, 8, 0, 1},
    '{8, 7, 0, 0, 0, 0, 7, 1},
    '{3, 5, 0, 0, 1, 0, 0, 2},
    '{0, 2, 0, 0, 1, 0, 0, 2}
  };

  always @(negedge clk) begin
    cyc++;
    if (ref_pulse) begin
      if (ref_prev) ref_wide = 1'b1;
      ref_iv   = cyc - last_ref;
      last_ref = cyc;
      ref_n++;
    end
    ref_prev = ref_pulse;
    up_run = tx_up ? up_run + 1 : 0;
    dn_run = tx_dn ? dn_run + 1 : 0;
    if (up_run > max_up) max_up = up_run;
    if (dn_run > max_dn) max_dn = dn_run;
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic steps(input int n);
    repeat (n) step();
  endtask

  task automatic do_reset();
    rst_n = 1'b0; ref_tick = 1'b0; tx_tick = 1'b0; rx_tick = 1'b0;
    steps(2);
    rst_n = 1'b1;
    ref_n = 0; max_up = 0; max_dn = 0; ref_wide = 1'b0;
  endtask

  task automatic wait_ref(input int n);
    int s = ref_n;
    int c = 0;
    while (ref_n < s + n && c < 20000) begin
      step();
      c++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog actual 1 expected 0");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    steps(2);
    chk("reset outputs", {ref_pulse, tx_up, tx_dn, tx_cph, tx_lock, rx_up, rx_dn, rx_cph, rx_lock}, 0);

    // vector table: tx loop only
    for (int v = 0; v < 9; v++) begin
      string tl, tw;
      ref_div = 12'(VEC[v][0]); tx_div = 14'(VEC[v][1]);
      tx_pd = 1'b0; rx_pd = 1'b1;
      tl = (VEC[v][7] == 1) ? "R7 lock" : (VEC[v][7] == 2) ? "R2 lock" : "R6 lock";
      tw = (VEC[v][7] == 1) ? "R7 width" : "R5 width";
      do_reset();
      for (int c = 0; c < 300; c++) begin
        ref_tick = (c >= VEC[v][2]);
        tx_tick  = (c >= VEC[v][3]);
        step();
      end
      chk(tl, int'(tx_lock), VEC[v][4]);
      chk({tw, " up"}, max_up, VEC[v][5]);
      chk({tw, " down"}, max_dn, VEC[v][6]);
    end
    rx_pd = 1'b0;

    // R1 period and pulse width
    ref_div = 12'd6;
    do_reset(); ref_tick = 1'b1;
    wait_ref(3);
    chk("R1 interval", ref_iv, 6);
    chk("R1 single-cycle pulse", int'(ref_wide), 0);

    // R3 first period is 5 even with R=20
    ref_div = 12'd20;
    do_reset(); ref_tick = 1'b1;
    steps(10);
    chk("R3 first period", ref_n, 1);
    // R3 mid-period change
    wait_ref(1);
    ref_div = 12'd6;
    wait_ref(1);
    chk("R3 old period completes", ref_iv, 20);
    wait_ref(1);
    chk("R3 new period", ref_iv, 6);

    // R2 clamp on reference
    ref_div = 12'd2;
    do_reset(); ref_tick = 1'b1;
    wait_ref(3);
    chk("R2 clamp interval", ref_iv, 5);

    // R4 ticks every other cycle
    ref_div = 12'd5;
    do_reset();
    for (int c = 0; c < 60; c++) begin
      ref_tick = c[0];
      step();
    end
    chk("R4 gated interval", ref_iv, 10);

    // R10 max reference value
    ref_div = 12'd4095;
    do_reset(); ref_tick = 1'b1;
    wait_ref(2);
    chk("R10 max interval", ref_iv, 4095);

    // R6 lock after exactly 8 comparisons
    ref_div = 12'd8; tx_div = 14'd8; rx_div = 14'd8;
    do_reset(); ref_tick = 1'b1; tx_tick = 1'b1; rx_tick = 1'b1;
    for (int c = 0; c < 200 && !tx_lock; c++) step();
    chk("R6 comparisons before lock", ref_n, 8);
    steps(20);
    chk("R6 rx lock", int'(rx_lock), 1);

    // R9 current select
    tx_cp = 1'b1; rx_cp = 1'b0;
    step();
    chk("R9 tx cp high", int'(tx_cph), 1);
    chk("R9 rx cp low", int'(rx_cph), 0);

    // R8 power down tx, rx unaffected
    tx_pd = 1'b1; rx_cp = 1'b1;
    step();
    chk("R8 tx outputs low", {tx_up, tx_dn, tx_lock, tx_cph}, 0);
    max_up = 0; max_dn = 0;
    steps(50);
    chk("R8 tx no pump activity", max_up + max_dn, 0);
    chk("R8 rx still locked", int'(rx_lock), 1);
    chk("R8 rx cp follows", int'(rx_cph), 1);
    tx_pd = 1'b0; tx_cp = 1'b0; rx_cp = 1'b0;

    // R6 loss of lock on frequency error
    do_reset(); ref_tick = 1'b1; tx_tick = 1'b1; rx_tick = 1'b1;
    steps(150);
    chk("R6 locked before step", int'(tx_lock), 1);
    tx_div = 14'd9;
    steps(150);
    chk("R6 lock lost", int'(tx_lock), 0);
    chk("R6 other loop keeps lock", int'(rx_lock), 1);

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule